// File: doc/BRIEF.md
# Serial Attenuator Programming Master

This block sits in a system clock domain and loads a step attenuator over a three-wire serial link. A host presents an attenuation word and pulses `start`. The block shifts the word out most significant bit first on a data line and a strobe clock. Throughout the shift the latch line stays low. After a settling gap it drives the latch line high for a fixed time and then lowers it, and that falling edge captures the word. A one-cycle `done` follows.

Every interval is a parameter counted in system clock cycles: the data setup before each strobe rise, the strobe high time, the data hold after each strobe fall, the gap before the latch rise, and the latch pulse width. At elaboration these counts are compared with the minimum serial timing for the configured system clock period. Those minimums are 10 ns data setup, 10 ns data hold, 30 ns strobe high, 30 ns strobe low, a strobe period of at least 100 ns, 10 ns from the last strobe fall to the latch rise, and a 30 ns latch pulse. A chain parameter lengthens the frame to several 6-bit words under a single latch pulse, for attenuators whose shift registers are cascaded.

Top module: `atten_serial_master`

## Requirements
- R1: During and after reset, with no request, `ser_clk`, `latch_en`, `busy` and `done` are all low.
- R2: Bits leave `word_in` from bit NB-1 down to bit 0, where NB = 6 x CHAIN. In each 6-bit word, bit 5 carries the 16 dB step and bit 0 carries the 0.5 dB step.
- R3: Each bit cell spans SETUP_CYC + HIGH_CYC + HOLD_CYC cycles. `ser_data` takes the new bit at the start of the cell. `ser_clk` stays low for SETUP_CYC cycles, high for HIGH_CYC cycles, then low for HOLD_CYC cycles. `ser_data` does not change from the start of the cell until the end of the hold phase.
- R4: `latch_en` stays low while bits are shifted. After the last strobe fall it stays low for a further HOLD_CYC + GAP_CYC cycles.
- R5: `latch_en` is high for exactly PULSE_CYC consecutive cycles per frame. It never rises while `ser_clk` is high.
- R6: A start accepted at clock edge E0 makes `busy` high for the next NB x (SETUP_CYC + HIGH_CYC + HOLD_CYC) + GAP_CYC + PULSE_CYC cycles. `done` is high for exactly the single cycle that follows, which is also the first cycle with `latch_en` low again.
- R7: A `start` seen while `busy` is high is ignored. Neither the frame in progress nor the word being sent is altered.
- R8: With CHAIN = 2, all 12 bits of `word_in` are shifted under one latch pulse, upper word first.
- R9: A `start` in the cycle where `done` is high is accepted, so frames can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to send `word_in`, sampled on the clock edge |
| word_in | input | 6 x CHAIN | Attenuation word(s), captured when a start is accepted |
| ser_data | output | 1 | Serial data line |
| ser_clk | output | 1 | Serial strobe clock, rests low |
| latch_en | output | 1 | Latch line, rests low, pulses high to latch |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
All outputs come from state registers that update on the edge which accepts `start`. Output values therefore begin one cycle later. The bench numbers that first cycle k = 0 and derives every expected level as a function of k. Within a bit cell, k modulo the cell length gives the phase, and `done` falls due at k = NB x cell + GAP_CYC + PULSE_CYC. The bench drives inputs and samples outputs on falling clock edges, and compares every cycle of each frame against that timetable. Ignored starts and linked frames are placed on exact k values, so the point each one lands on is known.

// File: rtl/asm_pkg.sv
package asm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_HOLD,
    ST_GAP,
    ST_PULSE
  } asm_state_t;

  // Smallest cycle count that covers a time in ns at a clock period in ps.
  function automatic int cyc_for_ns(input int ns, input int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  // Cycles from the accepting edge until done is due.
  function automatic int frame_cycles(input int nbits, input int s, input int h,
                                      input int d, input int g, input int l);
    return nbits * (s + h + d) + g + l;
  endfunction

  function automatic int max5(input int a, input int b, input int c,
                              input int d, input int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/asm_timer.sv
module asm_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/asm_shifter.sv
module asm_shifter #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [N-1:0] din,
  output logic         msb
);
  logic [N-1:0] shreg;

  generate
    if (N > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n)      shreg <= '0;
        else if (load)   shreg <= din;
        else if (shift)  shreg <= {shreg[N-2:0], 1'b0};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)      shreg <= '0;
        else if (load)   shreg <= din;
      end
    end
  endgenerate

  assign msb = shreg[N-1];
endmodule

// File: rtl/asm_seq.sv
module asm_seq
  import asm_pkg::*;
#(
  parameter int NB        = 6,
  parameter int TW        = 4,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 5,
  parameter int HOLD_CYC  = 3,
  parameter int GAP_CYC   = 2,
  parameter int PULSE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tmr_zero,
  output asm_state_t    state,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          sh_load,
  output logic          sh_shift,
  output logic          accept,
  output logic          done
);
  localparam int BW = (NB > 1) ? $clog2(NB) : 1;

  asm_state_t    nxt;
  logic [BW-1:0] bits_left;
  logic          last_bit;
  logic          fin;

  assign last_bit = (bits_left == '0);
  assign accept   = (state == ST_IDLE) && start;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    fin      = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        nxt = ST_SETUP; tmr_load = 1'b1; tmr_val = TW'(SETUP_CYC - 1); sh_load = 1'b1;
      end
      ST_SETUP: if (tmr_zero) begin
        nxt = ST_HIGH; tmr_load = 1'b1; tmr_val = TW'(HIGH_CYC - 1);
      end
      ST_HIGH: if (tmr_zero) begin
        nxt = ST_HOLD; tmr_load = 1'b1; tmr_val = TW'(HOLD_CYC - 1);
      end
      ST_HOLD: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          nxt = ST_GAP; tmr_val = TW'(GAP_CYC - 1);
        end else begin
          nxt = ST_SETUP; tmr_val = TW'(SETUP_CYC - 1); sh_shift = 1'b1;
        end
      end
      ST_GAP: if (tmr_zero) begin
        nxt = ST_PULSE; tmr_load = 1'b1; tmr_val = TW'(PULSE_CYC - 1);
      end
      ST_PULSE: if (tmr_zero) begin
        nxt = ST_IDLE; fin = 1'b1;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bits_left <= '0;
      done      <= 1'b0;
    end else begin
      state <= nxt;
      done  <= fin;
      if (sh_load)       bits_left <= BW'(NB - 1);
      else if (sh_shift) bits_left <= bits_left - 1'b1;
    end
  end
endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
  import asm_pkg::*;
#(
  parameter int WORD_W        = 6,
  parameter int CHAIN         = 1,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int SETUP_CYC     = 2,
  parameter int HIGH_CYC      = 5,
  parameter int HOLD_CYC      = 3,
  parameter int GAP_CYC       = 2,
  parameter int PULSE_CYC     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [WORD_W*CHAIN-1:0]   word_in,
  output logic                      ser_data,
  output logic                      ser_clk,
  output logic                      latch_en,
  output logic                      busy,
  output logic                      done
);
  localparam int NB      = WORD_W * CHAIN;
  localparam int MAXC    = max5(SETUP_CYC, HIGH_CYC, HOLD_CYC, GAP_CYC, PULSE_CYC);
  localparam int TW      = $clog2(MAXC + 1);
  localparam int MIN_SU  = cyc_for_ns(10, CLK_PERIOD_PS);
  localparam int MIN_HD  = cyc_for_ns(10, CLK_PERIOD_PS);
  localparam int MIN_HI  = cyc_for_ns(30, CLK_PERIOD_PS);
  localparam int MIN_LO  = cyc_for_ns(30, CLK_PERIOD_PS);
  localparam int MIN_PER = cyc_for_ns(100, CLK_PERIOD_PS);
  localparam int MIN_GAP = cyc_for_ns(10, CLK_PERIOD_PS);
  localparam int MIN_LEP = cyc_for_ns(30, CLK_PERIOD_PS);

  generate
    if (SETUP_CYC < MIN_SU || SETUP_CYC < 1) begin : g_bad_setup
      $error("setup interval too short for the serial timing");
    end
    if (HOLD_CYC < MIN_HD || HOLD_CYC < 1) begin : g_bad_hold
      $error("hold interval too short for the serial timing");
    end
    if (HIGH_CYC < MIN_HI || HIGH_CYC < 1) begin : g_bad_high
      $error("strobe high interval too short");
    end
    if (SETUP_CYC + HOLD_CYC < MIN_LO) begin : g_bad_low
      $error("strobe low interval too short");
    end
    if (SETUP_CYC + HIGH_CYC + HOLD_CYC < MIN_PER) begin : g_bad_period
      $error("strobe period faster than allowed");
    end
    if (GAP_CYC < MIN_GAP || GAP_CYC < 1) begin : g_bad_gap
      $error("latch gap too short");
    end
    if (PULSE_CYC < MIN_LEP || PULSE_CYC < 1) begin : g_bad_pulse
      $error("latch pulse too short");
    end
  endgenerate

  asm_state_t    state;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          sh_load;
  logic          shift_evt;
  logic          accept;

  asm_seq #(
    .NB(NB), .TW(TW), .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC),
    .HOLD_CYC(HOLD_CYC), .GAP_CYC(GAP_CYC), .PULSE_CYC(PULSE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tmr_zero(tmr_zero),
    .state(state), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .sh_load(sh_load), .sh_shift(shift_evt), .accept(accept), .done(done)
  );

  asm_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_zero)
  );

  asm_shifter #(.N(NB)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .shift(shift_evt),
    .din(word_in), .msb(ser_data)
  );

  assign ser_clk  = (state == ST_HIGH);
  assign latch_en = (state == ST_PULSE);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/asm_checker.sv
module asm_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic ser_clk,
  input logic ser_data,
  input logic latch_en,
  input logic done,
  input logic shift_evt,
  input logic accept
);
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !latch_en)); // R1
  AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R3
  AST_DATA_STEADY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> $stable(ser_data)); // R3
  AST_SHIFT_WHEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |-> (!ser_clk && !latch_en)); // R3
  AST_LATCH_NOT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> !latch_en); // R4
  AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(latch_en) && !latch_en && !busy)); // R5
  AST_ACCEPT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |-> !accept); // R7
endmodule

bind atten_serial_master asm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .ser_clk(ser_clk),
  .ser_data(ser_data), .latch_en(latch_en), .done(done),
  .shift_evt(shift_evt), .accept(accept)
);

// File: tb/atten_serial_master_test.sv
module atten_serial_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, ch_start = 1'b0;
  logic [5:0]  word = '0;
  logic [11:0] ch_word = '0;
  logic        sdata, sclk, le, busy, done;
  logic        c_sdata, c_sclk, c_le, c_busy, c_done;
  int          checks = 0, errors = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  atten_serial_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_in(word),
    .ser_data(sdata), .ser_clk(sclk), .latch_en(le), .busy(busy), .done(done)
  );

  atten_serial_master #(
    .CHAIN(2), .SETUP_CYC(1), .HIGH_CYC(5), .HOLD_CYC(4), .GAP_CYC(1), .PULSE_CYC(3)
  ) uut_ch (
    .clk(clk), .rst_n(rst_n), .start(ch_start), .word_in(ch_word),
    .ser_data(c_sdata), .ser_clk(c_sclk), .latch_en(c_le), .busy(c_busy), .done(c_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected levels k cycles after the accepting edge.
  function automatic bit e_sclk(int k, int nb, int s, int h, int d);
    int p = s + h + d;
    if (k >= nb * p) return 1'b0;
    return ((k % p) >= s) && ((k % p) < s + h);
  endfunction
  function automatic bit e_le(int k, int nb, int s, int h, int d, int g, int l);
    int base = nb * (s + h + d) + g;
    return (k >= base) && (k < base + l);
  endfunction

  task automatic run_frame(input bit sel, input logic [11:0] w, input int ign_k,
                           input bit pre, input bit link, input logic [11:0] nxt,
                           input string tag_b);
    int nb = sel ? 12 : 6;
    int s = sel ? 1 : 2, h = 5, d = sel ? 4 : 3, g = sel ? 1 : 2, l = sel ? 3 : 4;
    int p = s + h + d;
    int t = nb * (s + h + d) + g + l;
    bit a_sd, a_sc, a_le, a_bs, a_dn;
    string tg;
    if (!pre) begin
      @(negedge clk);
      if (sel) begin ch_start = 1'b1; ch_word = w; end
      else begin start = 1'b1; word = w[5:0]; end
    end
    @(negedge clk);
    ch_start = 1'b0; start = 1'b0;
    for (int k = 0; k <= t; k++) begin
      if (k > 0) @(negedge clk);
      if (k == ign_k + 1) begin start = 1'b0; ch_start = 1'b0; end
      a_sd = sel ? c_sdata : sdata; a_sc = sel ? c_sclk : sclk;
      a_le = sel ? c_le : le;       a_bs = sel ? c_busy : busy;
      a_dn = sel ? c_done : done;
      tg = (tag_b != "") ? tag_b : "R3";
      chk(a_sc == e_sclk(k, nb, s, h, d), {tg, " ser_clk"}, a_sc, e_sclk(k, nb, s, h, d));
      tg = (tag_b != "") ? tag_b : ((k < nb * p + g) ? "R4" : "R5");
      chk(a_le == e_le(k, nb, s, h, d, g, l), {tg, " latch_en"}, a_le, e_le(k, nb, s, h, d, g, l));
      tg = (tag_b != "") ? tag_b : "R6";
      chk(a_bs == (k < t), {tg, " busy"}, a_bs, (k < t));
      chk(a_dn == (k == t), {tg, " done"}, a_dn, (k == t));
      if (k < nb * p) begin
        tg = (tag_b != "") ? tag_b : "R2";
        chk(a_sd == w[nb - 1 - k / p], {tg, " ser_data"}, a_sd, w[nb - 1 - k / p]);
      end
      if (k == ign_k) begin
        if (sel) begin ch_start = 1'b1; ch_word = ~w; end
        else begin start = 1'b1; word = ~w[5:0]; end
      end
      if (k == t && link) begin
        if (sel) begin ch_start = 1'b1; ch_word = nxt; end
        else begin start = 1'b1; word = nxt[5:0]; end
      end
    end
    if (!link) begin
      @(negedge clk);
      a_bs = sel ? c_busy : busy; a_dn = sel ? c_done : done;
      chk(!a_dn, "R6 done single cycle", a_dn, 0);
      chk(!a_bs, "R6 idle after frame", a_bs, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(!sclk && !le && !busy && !done, "R1 outputs in reset",
        {sclk, le, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sclk && !le && !busy && !done, "R1 outputs idle after reset",
        {sclk, le, busy, done}, 0);
    // Directed words: all zero, all one, single step bits.
    run_frame(1'b0, 12'h000, -1, 1'b0, 1'b0, 12'h0, "");
    run_frame(1'b0, 12'h03F, -1, 1'b0, 1'b0, 12'h0, "");
    run_frame(1'b0, 12'h020, -1, 1'b0, 1'b0, 12'h0, "R2");
    run_frame(1'b0, 12'h001, -1, 1'b0, 1'b0, 12'h0, "R2");
    // R7: starts while busy at the first cycle and near the end.
    run_frame(1'b0, 12'h02A, 0, 1'b0, 1'b0, 12'h0, "R7");
    run_frame(1'b0, 12'h015, 63, 1'b0, 1'b0, 12'h0, "R7");
    // R9: back-to-back frames with no idle cycle.
    run_frame(1'b0, 12'h011, -1, 1'b0, 1'b1, 12'h02E, "R9");
    run_frame(1'b0, 12'h02E, -1, 1'b1, 1'b0, 12'h0, "R9");
    // R8: chained 12-bit frame under one latch pulse.
    run_frame(1'b1, 12'hA5C, -1, 1'b0, 1'b0, 12'h0, "R8");
    run_frame(1'b1, 12'h3F1, 20, 1'b0, 1'b0, 12'h0, "R8");
    // Random mix.
    for (int i = 0; i < 30; i++) begin
      logic [11:0] w = 12'($urandom_range(0, 63));
      int ik = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 60)) : -1;
      run_frame(1'b0, w, ik, 1'b0, 1'b0, 12'h0, "");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule